// File: doc/BRIEF.md
# Dual-Path Reset Controller with Guarded Retained Bank

This block turns an external, possibly noisy, active-low reset into the reset signals a small processor-style system needs. Two detector inputs model two sensitivities of the same reset line. The "full" input trips only on a sound, full-length pulse. The "any" input trips on every pulse, runts included. Each detector is a single latch. It is set asynchronously while its input is low and cleared at the first clock edge that finds the input high. These two latches are the only asynchronously set state in the block.

The "any" latch feeds a two-stage synchronizer, and its output becomes the core's synchronous active-low reset. The "full" latch does not reset any storage. It only gates the outward-facing I/O enable, without waiting for a clock. A sound pulse therefore silences the pins at once. A runt that only the sensitive detector catches silences them two edges later, through the clean synchronous path, so the pins do not glitch.

The block also holds a small register bank that no reset clears. Write requests are registered on a clock edge and committed on the next one. A commit happens only while the synchronized core reset is inactive. A reset that lands near a clock edge therefore cannot bend the address of a write in flight.

Top module: `dprst_ctrl`

## Requirements
- R1: While `full_rst_n` is low, `io_en` is 0 within the same clock phase, with no clock edge needed.
- R2: A pulse on `any_rst_n` alone that begins and ends inside one clock period leaves `io_en` at 1 after the next rising edge. `io_en` reads 0 after the second rising edge that follows the pulse start.
- R3: If `full_rst_n` falls within two clock edges after such a runt, `io_en` drops at once, whether or not the runt has taken effect yet.
- R4: `core_rst_n` goes low after the second rising edge after `any_rst_n` falls. It returns high at the third rising edge after `any_rst_n` rises. This covers two cycles beyond the detector release.
- R5: `io_en` returns to 1 one rising edge after `core_rst_n` has returned to 1, provided `full_rst_n` is high.
- R6: `wr_req`, `wr_addr` and `wr_data` are sampled on a rising edge. The bank entry is updated at the following edge, and `wr_commit` is high during the cycle in between. `rd_data` shows the entry at `rd_addr` combinationally.
- R7: A request sampled on an edge where `core_rst_n` was low is discarded. `wr_commit` is never 1 while `core_rst_n` is 0.
- R8: No reset, clean or runt, changes any bank entry.
- R9: A reset pulse that arrives just before the commit edge of a write to address 15 leaves address 14 untouched, and the write lands at 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| full_rst_n | input | 1 | Reset as seen by the low-sensitivity detector (sound pulses only), active low |
| any_rst_n | input | 1 | Reset as seen by the high-sensitivity detector (any pulse), active low |
| wr_req | input | 1 | Write request to the retained bank |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Bank contents at `rd_addr` |
| wr_commit | output | 1 | Guarded write enable applied to the bank this cycle |
| core_rst_n | output | 1 | Synchronized core reset, active low |
| io_en | output | 1 | Enable for outward-facing pins |

## Verification
Two things can fall in the same cycle: a bank write being committed and a reset pulse arriving just ahead of that commit edge. The bench provokes this by issuing a write to address 15 and dropping both reset inputs half a nanosecond before the commit edge. It then checks that address 15 holds the new value and address 14 its old one. The other overlap is a runt followed by a sound pulse before the runt's two edges have passed. There the bench checks that `io_en` falls immediately. A behavioural model compares `io_en`, `core_rst_n`, `wr_commit` and `rd_data` on every clock.

// File: rtl/dprst_pkg.sv
// Shared constants and helpers for the dual-path reset controller.
// Assumes: nothing beyond a single clock domain.
package dprst_pkg;
    // Minimum synchronizer depth the core reset path relies on.
    localparam int unsigned SYNC_DEPTH_MIN = 2;

    // Pins may drive only when the fast detector is quiet and the core
    // reset has been inactive for the current and the previous cycle.
    function automatic logic io_allow(input logic fast_tripped,
                                      input logic core_n,
                                      input logic core_n_prev);
        return !fast_tripped && core_n && core_n_prev;
    endfunction
endpackage

// File: rtl/dprst_det.sv
// Reset detector latch: set asynchronously while pin_n is low, cleared
// at the first rising clock edge that finds pin_n high.
// Assumes: this is one of only two asynchronously set elements in the block.
module dprst_det (
    input  logic clk,
    input  logic pin_n,
    output logic tripped
);
    // Latch the detection asynchronously, release it on the clock.
    always_ff @(posedge clk or negedge pin_n) begin
        if (!pin_n) tripped <= 1'b1;
        else        tripped <= 1'b0;
    end
endmodule

// File: rtl/dprst_sync.sv
// Plain shift-chain synchronizer without any reset of its own.
// Assumes: STAGES >= 2; the output equals din delayed by STAGES edges.
module dprst_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First stage samples the detector latch.
            always_ff @(posedge clk) chain[0] <= din;
        end else begin : g_next
            // Later stages shift the sample towards the output.
            always_ff @(posedge clk) chain[g] <= chain[g-1];
        end
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/dprst_bank.sv
// Retained register bank with a registered write port. The request
// register resets synchronously; address, data and the bank never reset.
// Assumes: core_rst_n is already synchronous to clk.
module dprst_bank #(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              core_rst_n,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              wr_commit
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store [DEPTH];
    logic              req_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;

    // Capture the request flag; drop it while the core is in reset.
    always_ff @(posedge clk) begin
        if (!core_rst_n) req_q <= 1'b0;
        else             req_q <= wr_req;
    end

    // Capture address and data on the clock only; never reset.
    always_ff @(posedge clk) begin
        addr_q <= wr_addr;
        data_q <= wr_data;
    end

    assign wr_commit = req_q && core_rst_n;

    // Commit a captured write; the bank has no reset at all.
    always_ff @(posedge clk) begin
        if (wr_commit) store[addr_q] <= data_q;
    end

    assign rd_data = store[rd_addr];
endmodule

// File: rtl/dprst_ctrl.sv
// Top of the dual-path reset controller. The fast detector gates the I/O
// enable combinationally; the sensitive detector feeds a synchronizer that
// produces the core reset, which in turn guards the retained bank.
// Assumes: full_rst_n low implies any_rst_n low (a sound pulse trips both).
module dprst_ctrl #(
    parameter int unsigned ADDR_W      = 4,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = dprst_pkg::SYNC_DEPTH_MIN
) (
    input  logic              clk,
    input  logic              full_rst_n,
    input  logic              any_rst_n,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              wr_commit,
    output logic              core_rst_n,
    output logic              io_en
);
    logic io_lat;
    logic main_lat;
    logic main_sync;
    logic core_n_q;

    dprst_det u_det_io (.clk(clk), .pin_n(full_rst_n), .tripped(io_lat));
    dprst_det u_det_main (.clk(clk), .pin_n(any_rst_n), .tripped(main_lat));

    dprst_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .din(main_lat), .dout(main_sync)
    );

    assign core_rst_n = !main_sync;

    // Remember last cycle's core reset to hold the pins off one more cycle.
    always_ff @(posedge clk) core_n_q <= core_rst_n;

    assign io_en = dprst_pkg::io_allow(io_lat, core_rst_n, core_n_q);

    dprst_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
        .clk(clk), .core_rst_n(core_rst_n), .wr_req(wr_req),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .wr_commit(wr_commit)
    );
endmodule

// File: rtl/dprst_chk.sv
// Property checker for dprst_ctrl, attached by bind.
// Assumes: properties are idle until the synchronous reset state is known.
module dprst_chk #(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              io_lat,
    input logic              main_lat,
    input logic              core_rst_n,
    input logic              core_n_q,
    input logic              io_en,
    input logic              wr_commit,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0] rd_data
);
    // R1
    io_gate_chk: assert property (@(posedge clk)
        disable iff ($isunknown({core_rst_n, core_n_q}))
        io_lat |-> !io_en);

    // R4
    core_entry_chk: assert property (@(posedge clk)
        disable iff ($isunknown({core_rst_n, core_n_q}))
        $fell(core_rst_n) |-> $past(main_lat, 2));

    // R5
    io_return_chk: assert property (@(posedge clk)
        disable iff ($isunknown({core_rst_n, core_n_q}))
        $rose(io_en) |-> (core_rst_n && $past(core_rst_n) && !io_lat));

    // R7
    write_guard_chk: assert property (@(posedge clk)
        disable iff ($isunknown({core_rst_n, core_n_q}))
        !core_rst_n |-> !wr_commit);

    // R8
    bank_hold_chk: assert property (@(posedge clk)
        disable iff ($isunknown({core_rst_n, core_n_q, rd_data}))
        !wr_commit |=> (!$stable(rd_addr) || $stable(rd_data)));
endmodule

bind dprst_ctrl dprst_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .io_lat(io_lat), .main_lat(main_lat),
    .core_rst_n(core_rst_n), .core_n_q(core_n_q), .io_en(io_en),
    .wr_commit(wr_commit), .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/sim_dprst_ctrl.sv
`timescale 1ns/1ps
module sim_dprst_ctrl;
    localparam int AW = 4;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          full_rst_n = 1'b0;
    logic          any_rst_n = 1'b0;
    logic          wr_req = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic          wr_commit, core_rst_n, io_en;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    dprst_ctrl #(.ADDR_W(AW), .DATA_W(DW)) u0 (
        .clk(clk), .full_rst_n(full_rst_n), .any_rst_n(any_rst_n),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .wr_commit(wr_commit),
        .core_rst_n(core_rst_n), .io_en(io_en)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit          m_io = 0, m_main = 0;
    bit          m_core_n = 1, m_core_prev_n = 1;
    bit          m_req = 0;
    logic [AW-1:0] m_addr = '0;
    logic [DW-1:0] m_data = '0;
    logic [DW-1:0] exp_bank [16];
    bit          known [16];
    bit          hist [$];
    int          warm = 0;

    always @(negedge full_rst_n) m_io = 1;
    always @(negedge any_rst_n)  m_main = 1;

    always @(posedge clk) begin
        if (m_req && m_core_n) begin
            exp_bank[m_addr] = m_data;
            known[m_addr] = 1;
        end
        m_req  = m_core_n ? wr_req : 1'b0;
        m_addr = wr_addr;
        m_data = wr_data;
        hist.push_front(m_main);
        if (hist.size() > 3) void'(hist.pop_back());
        m_core_prev_n = m_core_n;
        if (hist.size() >= 2) m_core_n = !hist[1];
        m_main = !any_rst_n;
        m_io   = !full_rst_n;
        warm++;
    end

    // Compare outputs against the model once per cycle, away from the edge.
    always @(negedge clk) begin
        if (warm >= 6 && !done) begin
            chk("R1 io_en vs model", io_en, !m_io && m_core_n && m_core_prev_n);
            chk("R4 core_rst_n vs model", core_rst_n, m_core_n);
            chk("R7 wr_commit vs model", wr_commit, m_req && m_core_n);
            if (known[rd_addr]) chk("R8 rd_data vs model", rd_data, exp_bank[rd_addr]);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_req = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_req = 0;
        @(negedge clk);
    endtask

    task automatic read_chk(input string tag, input logic [AW-1:0] a, input logic [DW-1:0] e);
        @(negedge clk);
        rd_addr = a;
        #0.5;
        chk(tag, rd_data, e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic [DW-1:0] pat(input int i);
        return DW'(i * 17 + 3);
    endfunction

    // ---------------- directed sequence ----------------
    initial begin
        // Power-up: sound reset held for several cycles.
        idle(6);
        full_rst_n = 1; any_rst_n = 1;
        idle(6);
        chk("R5 io_en after power-up", io_en, 1);
        chk("R4 core_rst_n after power-up", core_rst_n, 1);

        // R6: fill the bank and read samples back.
        for (int i = 0; i < 16; i++) do_write(AW'(i), pat(i));
        read_chk("R6 readback addr 3", 4'd3, pat(3));
        read_chk("R6 readback addr 14", 4'd14, pat(14));

        // R1: sound pulse drops io_en before any clock edge.
        @(negedge clk); #1;
        full_rst_n = 0; any_rst_n = 0;
        #0.5;
        chk("R1 io_en immediate drop", io_en, 0);
        idle(3);
        full_rst_n = 1; any_rst_n = 1;          // release at a falling edge
        @(negedge clk);
        chk("R4 core low after release edge 1", core_rst_n, 0);
        @(negedge clk);
        chk("R4 core low after release edge 2", core_rst_n, 0);
        @(negedge clk);
        chk("R4 core high after release edge 3", core_rst_n, 1);
        chk("R5 io_en still low edge 3", io_en, 0);
        @(negedge clk);
        chk("R5 io_en back edge 4", io_en, 1);
        read_chk("R8 addr 0 kept after sound reset", 4'd0, pat(0));
        read_chk("R8 addr 9 kept after sound reset", 4'd9, pat(9));

        // R2: runt on the sensitive input only.
        @(negedge clk); #1;
        any_rst_n = 0; #1; any_rst_n = 1;
        chk("R2 io_en no glitch at runt", io_en, 1);
        @(negedge clk);
        chk("R2 io_en high after edge 1", io_en, 1);
        chk("R4 core high after edge 1", core_rst_n, 1);
        // R7: request offered while the core is about to be in reset.
        @(negedge clk);
        chk("R2 io_en low after edge 2", io_en, 0);
        chk("R4 core low after edge 2", core_rst_n, 0);
        wr_req = 1; wr_addr = 4'd5; wr_data = 8'h3C;
        @(negedge clk);
        wr_req = 0;
        chk("R7 no commit for request taken in reset", wr_commit, 0);
        chk("R4 core high after runt edge 3", core_rst_n, 1);
        @(negedge clk);
        chk("R5 io_en back after runt", io_en, 1);
        idle(2);
        read_chk("R7 addr 5 unchanged", 4'd5, pat(5));
        read_chk("R8 addr 12 kept after runt", 4'd12, pat(12));

        // R3: runt, then a sound pulse one edge later.
        @(negedge clk); #1;
        any_rst_n = 0; #1; any_rst_n = 1;
        @(negedge clk);
        chk("R3 io_en high before second pulse", io_en, 1);
        #1;
        full_rst_n = 0; any_rst_n = 0;
        #0.5;
        chk("R3 io_en drops at once", io_en, 0);
        idle(3);
        full_rst_n = 1; any_rst_n = 1;
        idle(6);
        chk("R5 io_en restored after R3 case", io_en, 1);

        // R9: reset lands just before the commit edge of a write to 15.
        @(negedge clk);
        wr_req = 1; wr_addr = 4'd15; wr_data = 8'hA5;
        @(negedge clk);
        wr_req = 0;
        #2;
        full_rst_n = 0; any_rst_n = 0;
        #0.5;
        chk("R1 io_en low during collision pulse", io_en, 0);
        idle(3);
        full_rst_n = 1; any_rst_n = 1;
        idle(6);
        read_chk("R9 addr 15 holds new data", 4'd15, 8'hA5);
        read_chk("R9 addr 14 untouched", 4'd14, pat(14));

        idle(2);
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Watchdog: a hung run ends as a failure.
    initial begin
        #(5.0 * 200000);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule